// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block is a register-mapped asynchronous serial port. A one-word transmit holding buffer feeds a transmit shift register, and a receive shift register feeds a one-word receive buffer. Software selects the character length, the parity mode, the number of stop bits, the per-direction enables, a master enable and the cause of the transmit interrupt through two small control registers. A status register reports the buffer and shifter conditions, three error conditions and an error summary.

Bit timing comes from an external baud tick, a one-cycle pulse. The block counts 16 ticks per serial bit and samples received bits near the middle of each bit. The register bus is a plain two-bit address with write and read strobes. Read data is combinational. A read strobe on the data address has side effects.

Top module: `uart_sio`

## Requirements
- R1: The serial line idles high. Every serial bit lasts 16 baud ticks. A transmitted frame is, in order, a 0 start bit, the data bits with the LSB first, an optional parity bit, and then the stop bits, all of which are 1.
- R2: Format register bit 0 sets the character length: 0 gives 8 data bits and 1 gives 7 data bits. In 7-bit mode, bit 7 of the received data reads 0.
- R3: Format bit 1 turns parity on. Format bit 2 sets the parity sense: 0 means the data bits plus the parity bit hold an even number of ones, and 1 means they hold an odd number.
- R4: Format bit 3 sets the number of transmitted stop bits: 0 gives one and 1 gives two. The transmit-done flag goes to 1 only after the last stop bit has been sent. The receiver checks only the first stop bit.
- R5: The status register (address 1) holds the following flags. Bit 0 is transmit buffer empty (1 = empty). Bit 1 is receive buffer full. Bit 2 is transmit shift done (1 = shifter idle). After reset the status register reads 0x85.
- R6: A character that completes while the receive buffer is still full is discarded. The buffer keeps the earlier character, and the overrun flag (status bit 3) is set.
- R7: The parity error flag (status bit 4) and the framing error flag (status bit 5, set when the first stop bit is sampled as 0) are captured along with each accepted character. A read strobe on the data address (address 0) clears the buffer-full flag and all three error flags.
- R8: Status bit 6 reads as the OR of the overrun, parity and framing error flags.
- R9: Control bit 3 selects the transmit interrupt cause. With the bit at 0, `tx_irq` is high while the transmit buffer is empty. With the bit at 1, `tx_irq` is high while the transmit shifter is idle. In both cases the transmitter must be enabled.
- R10: Control bit 0 is the master enable, bit 1 enables transmit and bit 2 enables receive. A disabled receiver ignores the line. A disabled transmitter keeps the buffered character and holds the line high until it is enabled.
- R11: Unused register bits read as 1: status bit 7, and bits 7 to 4 of the control register (address 2) and the format register (address 3).
- R12: `rx_irq` is high while the receive buffer is full and the receiver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (side effect on address 0) |
| rdata | output | 8 | Read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default oversampling ratio of 16 and a baud tick on every second clock, so one serial bit lasts 32 clocks. The whole format space is only 16 combinations, so the bench sweeps every one of them in both directions. It compares each transmitted frame, bit by bit, against a frame that the bench assembles arithmetically, and it checks where the transmit-done flag rises. Directed cases then corrupt the parity bit or the stop bit, overrun the buffer, switch the interrupt cause in the middle of a frame, and toggle the enables.

// File: rtl/uart_sio_pkg.sv
package uart_sio_pkg;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_FMT  = 2'd3;

  typedef struct packed {
    logic stop2;
    logic par_odd;
    logic par_en;
    logic len7;
  } fmt_t;

  typedef struct packed {
    logic irq_on_done;
    logic rx_on;
    logic tx_on;
    logic port_on;
  } ctrl_t;

  // number of data bits in the character
  function automatic logic [3:0] data_bits(fmt_t f);
    return f.len7 ? 4'd7 : 4'd8;
  endfunction

  // total transmitted bits: start + data + parity + stops
  function automatic logic [3:0] tx_frame_len(fmt_t f);
    return 4'd1 + data_bits(f) + {3'b0, f.par_en} + {3'b0, f.stop2} + 4'd1;
  endfunction

  // index of the first stop bit; 0 is the start bit
  function automatic logic [3:0] rx_stop_idx(fmt_t f);
    return data_bits(f) + {3'b0, f.par_en} + 4'd1;
  endfunction

  function automatic logic [7:0] mask_data(logic [7:0] d, fmt_t f);
    return {d[7] & ~f.len7, d[6:0]};
  endfunction

  function automatic logic parity_of(logic [7:0] d, fmt_t f);
    return (^mask_data(d, f)) ^ f.par_odd;
  endfunction

  // frame with the LSB sent first, padded with ones
  function automatic logic [11:0] build_frame(logic [7:0] d, fmt_t f);
    logic [11:0] r;
    logic p;
    r = '1;
    p = f.par_en ? parity_of(d, f) : 1'b1;
    r[0] = 1'b0;
    if (f.len7) begin
      r[7:1] = d[6:0];
      r[8]   = p;
    end else begin
      r[8:1] = d;
      r[9]   = p;
    end
    return r;
  endfunction

endpackage

// File: rtl/uart_sio_tx.sv
module uart_sio_tx
  import uart_sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       pending,
  input  logic [7:0] din,
  input  fmt_t       fmt,
  output logic       load,
  output logic       busy,
  output logic       txd
);
  localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);

  logic [11:0]   sh;
  logic [3:0]    left;
  logic [SW-1:0] sub;

  assign load = enable && !busy && pending;
  assign txd  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      sub  <= '0;
    end else if (!enable) begin
      busy <= 1'b0;
      sh   <= '1;
    end else if (load) begin
      busy <= 1'b1;
      sh   <= build_frame(din, fmt);
      left <= tx_frame_len(fmt);
      sub  <= '0;
    end else if (busy && tick) begin
      if (sub == SUB_LAST) begin
        sub  <= '0;
        sh   <= {1'b1, sh[11:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_sio_rx.sv
module uart_sio_rx
  import uart_sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       rxd,
  input  fmt_t       fmt,
  output logic       done,
  output logic [7:0] data,
  output logic       par_bad,
  output logic       stop_bad
);
  localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] SUB_MID  = SW'(OVS / 2 - 1);

  logic          busy;
  logic [3:0]    idx;
  logic [SW-1:0] sub;
  logic [7:0]    shreg;
  logic          pbit;
  logic          mid;

  assign mid      = busy && tick && (sub == SUB_MID);
  assign done     = mid && (idx == rx_stop_idx(fmt));
  assign data     = mask_data(shreg, fmt);
  assign par_bad  = fmt.par_en && (pbit != parity_of(shreg, fmt));
  assign stop_bad = !rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      sub   <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (!enable) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (!rxd) begin
        busy <= 1'b1;
        idx  <= '0;
        sub  <= '0;
      end
    end else if (tick) begin
      sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
      if (mid) begin
        idx <= idx + 4'd1;
        if (idx == 4'd0) begin
          if (rxd) busy <= 1'b0;
        end else if (idx <= data_bits(fmt)) begin
          shreg[3'(idx - 4'd1)] <= rxd;
        end else if (fmt.par_en && idx == data_bits(fmt) + 4'd1) begin
          pbit <= rxd;
        end
        if (done) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_sio.sv
module uart_sio
  import uart_sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_irq,
  output logic       rx_irq
);
  ctrl_t      ctrl;
  fmt_t       fmt;
  logic [7:0] tx_buf, rx_buf;
  logic       tx_empty, rx_full, ovr, pe, fe;
  logic [1:0] rx_sync;

  // named internal events
  logic       tx_en, rx_en, tx_load, tx_busy, wr_data, rd_clr;
  logic       rx_done, rx_ovr_evt, rx_par_bad, rx_stop_bad;
  logic [7:0] rx_word;

  assign tx_en      = ctrl.port_on && ctrl.tx_on;
  assign rx_en      = ctrl.port_on && ctrl.rx_on;
  assign wr_data    = wr_en && addr == A_DATA;
  assign rd_clr     = rd_en && addr == A_DATA;
  assign rx_ovr_evt = rx_done && rx_full && !rd_clr;

  uart_sio_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .enable(tx_en),
    .pending(!tx_empty), .din(tx_buf), .fmt(fmt),
    .load(tx_load), .busy(tx_busy), .txd(txd)
  );

  uart_sio_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .enable(rx_en),
    .rxd(rx_sync[1]), .fmt(fmt), .done(rx_done), .data(rx_word),
    .par_bad(rx_par_bad), .stop_bad(rx_stop_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      fmt  <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl <= ctrl_t'(wdata[3:0]);
      if (addr == A_FMT)  fmt  <= fmt_t'(wdata[3:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf   <= '0;
      tx_empty <= 1'b1;
    end else if (wr_data) begin
      tx_buf   <= wdata;
      tx_empty <= 1'b0;
    end else if (tx_load) begin
      tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      pe      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      if (rd_clr) begin
        rx_full <= 1'b0;
        ovr     <= 1'b0;
        pe      <= 1'b0;
        fe      <= 1'b0;
      end
      if (rx_ovr_evt) begin
        ovr <= 1'b1;
      end else if (rx_done) begin
        rx_buf  <= rx_word;
        rx_full <= 1'b1;
        pe      <= rx_par_bad;
        fe      <= rx_stop_bad;
      end
    end
  end

  assign tx_irq = tx_en && (ctrl.irq_on_done ? !tx_busy : tx_empty);
  assign rx_irq = rx_en && rx_full;

  always_comb begin
    case (addr)
      A_DATA:  rdata = rx_buf;
      A_STAT:  rdata = {1'b1, ovr | pe | fe, fe, pe, ovr, !tx_busy, rx_full, tx_empty};
      A_CTRL:  rdata = {4'hF, ctrl};
      default: rdata = {4'hF, fmt};
    endcase
  end
endmodule

// File: rtl/uart_sio_chk.sv
module uart_sio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_load,
  input logic       wr_data,
  input logic       tx_empty,
  input logic       rx_ovr_evt,
  input logic [7:0] rx_buf,
  input logic       ovr,
  input logic       rd_clr,
  input logic       rx_done,
  input logic       rx_full,
  input logic [7:0] rdata,
  input logic [1:0] addr
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  p_empty_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !wr_data |=> tx_empty);
  p_ovr_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr_evt |=> $stable(rx_buf) && ovr);
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !rx_done |=> !rx_full && !ovr);
  p_err_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd1 |-> rdata[6] == (rdata[3] || rdata[4] || rdata[5]));
endmodule

bind uart_sio uart_sio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_load(tx_load),
  .wr_data(wr_data), .tx_empty(tx_empty), .rx_ovr_evt(rx_ovr_evt),
  .rx_buf(rx_buf), .ovr(ovr), .rd_clr(rd_clr), .rx_done(rx_done),
  .rx_full(rx_full), .rdata(rdata), .addr(addr)
);

// File: tb/sim_uart_sio.sv
`timescale 1ns/1ps
module sim_uart_sio;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, rxd = 1;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic txd, tx_irq, rx_irq;
  int checks = 0, errors = 0;

  uart_sio u0 (.clk(clk), .rst_n(rst_n), .baud_tick(tick), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .rxd(rxd),
    .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq));

  always #5 clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input bit clr, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = clr; #1 d = rdata;
    @(negedge clk); rd_en = 0; addr = 2'd1;
  endtask

  // expected frame, built as a bit list
  function automatic int flen(logic [3:0] f);
    return 1 + (f[0] ? 7 : 8) + int'(f[1]) + 1 + int'(f[3]);
  endfunction

  function automatic logic [11:0] fbits(logic [7:0] d, logic [3:0] f);
    logic [11:0] r = '1;
    int n = f[0] ? 7 : 8;
    int ones = 0;
    r[0] = 0;
    for (int i = 0; i < n; i++) begin r[i+1] = d[i]; ones += int'(d[i]); end
    if (f[1]) r[n+1] = ((ones % 2) == 1) ^ f[2];
    return r;
  endfunction

  task automatic send(input logic [11:0] b, input int n);
    for (int k = 0; k < n; k++) begin rxd = b[k]; repeat (32) @(negedge clk); end
    rxd = 1; repeat (40) @(negedge clk);
  endtask

  task automatic wait_start(output bit seen);
    seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin @(negedge clk); if (!txd) seen = 1; end
  endtask

  initial begin
    logic [7:0] v, d;
    logic [11:0] got, exp;
    bit seen;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(2'd1, 0, v);
    check(v == 8'h85, "R5 reset status", v, 8'h85);
    check(txd && !tx_irq && !rx_irq, "R1 reset idle", {txd, tx_irq, rx_irq}, 3'b100);
    wr(2'd2, 8'h07);
    rd(2'd2, 0, v);
    check(v == 8'hF7, "R11 ctrl unused bits", v, 8'hF7);

    // sweep all formats in both directions
    for (int f = 0; f < 16; f++) begin
      wr(2'd3, 8'(f));
      rd(2'd3, 0, v);
      check(v == (8'hF0 | 8'(f)), "R11 fmt readback", v, 8'hF0 | 8'(f));
      d = 8'hA5 ^ 8'(f * 37);
      n = flen(4'(f));
      exp = fbits(d, 4'(f));
      wr(2'd0, d);
      wait_start(seen);
      check(seen, "R1 tx start", 0, 1);
      repeat (16) @(negedge clk);
      got = '1;
      for (int k = 0; k < n; k++) begin
        got[k] = txd;
        if (k < n - 1) repeat (32) @(negedge clk);
      end
      rd(2'd1, 0, v);
      check(v[2] == 0, "R4 done not before last stop", v, 0);
      check(got == exp, "R1 R2 R3 R4 tx frame", got, exp);
      repeat (32) @(negedge clk);
      rd(2'd1, 0, v);
      check(v[2] == 1, "R4 done after frame", v, 1);
      d = 8'h3C + 8'(f * 53);
      send(fbits(d, 4'(f)), flen(4'(f)));
      rd(2'd1, 0, v);
      check(v == 8'h87, "R5 rx full no errors", v, 8'h87);
      check(rx_irq, "R12 rx irq", 0, 1);
      rd(2'd0, 1, v);
      exp = {4'b0, f[0] ? {1'b0, d[6:0]} : d};
      check(v == exp[7:0], "R2 rx data", v, exp);
      rd(2'd1, 0, v);
      check(v == 8'h85 && !rx_irq, "R7 R12 read clears", v, 8'h85);
    end

    // parity error
    wr(2'd3, 8'h02);
    exp = fbits(8'h5B, 4'h2); exp[9] = ~exp[9];
    send(exp, 11);
    rd(2'd1, 0, v);
    check(v == 8'hD7, "R3 R7 R8 parity error", v, 8'hD7);
    rd(2'd0, 1, v);
    rd(2'd1, 0, v);
    check(v == 8'h85, "R7 parity cleared", v, 8'h85);

    // framing error: stop bit 0
    wr(2'd3, 8'h00);
    exp = fbits(8'h81, 4'h0); exp[9] = 0;
    send(exp, 10);
    rd(2'd1, 0, v);
    check(v == 8'hE7, "R7 R8 framing error", v, 8'hE7);
    rd(2'd0, 1, v);
    check(v == 8'h81, "R7 data kept with framing error", v, 8'h81);

    // overrun
    send(fbits(8'h11, 4'h0), 10);
    send(fbits(8'h22, 4'h0), 10);
    rd(2'd1, 0, v);
    check(v == 8'hCF, "R6 R8 overrun", v, 8'hCF);
    rd(2'd0, 1, v);
    check(v == 8'h11, "R6 first char kept", v, 8'h11);

    // transmit interrupt source
    wr(2'd2, 8'h0F);
    wr(2'd0, 8'h6E);
    wait_start(seen);
    check(!tx_irq, "R9 done-source low while shifting", tx_irq, 0);
    wr(2'd2, 8'h07);
    check(tx_irq, "R9 empty-source high while shifting", tx_irq, 1);
    repeat (400) @(negedge clk);
    wr(2'd2, 8'h0F);
    check(tx_irq, "R9 done-source high when idle", tx_irq, 1);

    // enables
    wr(2'd2, 8'h06);
    send(fbits(8'h44, 4'h0), 10);
    rd(2'd1, 0, v);
    check(v == 8'h85, "R10 disabled receiver ignores line", v, 8'h85);
    wr(2'd0, 8'h99);
    seen = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (!txd) seen = 1; end
    rd(2'd1, 0, v);
    check(!seen && v == 8'h84, "R10 disabled transmitter holds", v, 8'h84);
    wr(2'd2, 8'h03);
    wait_start(seen);
    rd(2'd1, 0, v);
    check(seen && v[0] == 1, "R10 enable releases character", v, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule